// File: doc/BRIEF.md
# Two-Channel Latched Alarm Status and Interrupt Register

This block collects the alarm conditions of a two-channel line interface and turns them into one 8-bit status byte per channel and a single active-high interrupt line. Each alarm input goes through a two-flop synchroniser before edge detection. Each channel byte mixes two kinds of bit:

- Live bits follow the synchronised level of loss of signal and of the alarm indication signal.
- Sticky bits record that an event happened since the last read of that channel.

A host reads a byte by pulsing a one-cycle read strobe together with a channel select. The byte, as it stood before the read, appears on the read data output one cycle later. The same read clears that channel's sticky bits, including its interrupt flag. Live bits are never cleared by a read.

Bit 1 has a different meaning on each channel:

- Channel 0 records a device-reset event.
- Channel 1 records that the transmit or reference clock went missing.

The alarm indication signal raises an interrupt on both of its edges:

- On its rising edge, through the sticky bit.
- On its falling edge, through the interrupt flag alone.

The interrupt output is high while either channel's interrupt flag is set.

Top module: `alarm_status_regs`

## Requirements
- R1: The status byte is {live LOS, sticky LOS, live AIS, sticky AIS, sticky BPV, sticky overflow, sticky bit-1 event, interrupt flag}, from bit 7 down to bit 0.
- R2: Bit 1 of channel 0 is set by a rising edge of `rst_evt_i`. Bit 1 of channel 1 is set by a rising edge of `clk_lost_i`. A level that stays high does not set the bit again after a read.
- R3: After reset, the channel 0 byte reads 0xC3 and the channel 1 byte reads 0xC1, provided both LOS inputs are held high. `irq_o` is 1 after reset.
- R4: A live bit shows its input two clocks after the input changes. A LOS rising edge sets sticky LOS one clock later than the live bit. A BPV or overflow pulse of one cycle sets its sticky bit in the same way.
- R5: A strobe with select s returns channel s's byte on `rd_data_o` in the next cycle, taken before the clear. The strobe clears that channel's sticky bits and flag and leaves the other channel untouched.
- R6: A read never clears live LOS or live AIS.
- R7: A rising edge of AIS sets sticky AIS and the flag. A falling edge of AIS sets only the flag.
- R8: An event whose set falls in the same cycle as a clearing read of its channel stays set after that read.
- R9: `irq_o` is 1 exactly when at least one channel's interrupt flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_i | input | 2 | Loss-of-signal level per channel |
| ais_i | input | 2 | Alarm-indication level per channel |
| bpv_i | input | 2 | Bipolar-violation pulse per channel |
| ovf_i | input | 2 | Pulse-overflow pulse per channel |
| rst_evt_i | input | 1 | Device-reset event, bit 1 of channel 0 |
| clk_lost_i | input | 1 | Clock-absent level, bit 1 of channel 1 |
| rd_stb_i | input | 1 | One-cycle read strobe |
| rd_sel_i | input | 1 | Channel select for the read |
| rd_data_o | output | 8 | Byte captured by the last read |
| irq_o | output | 1 | Active-high interrupt |

## Verification
Directed patterns cover the following cases:

- Slow level changes on LOS and AIS. Comparing the first and second reads separates live bits from sticky bits.
- Single-cycle BPV and overflow pulses. These show that a short pulse is still caught.
- A held clock-lost level. This separates edge-setting from level-setting.
- A LOS edge placed exactly in the cycle of a read. This checks that the event survives the clear.

Interleaved reads of both channels show that a clear touches only the selected channel. A long random phase with mixed toggles and strobes is compared every clock against a behavioural model of the byte and the interrupt.

// File: rtl/alarm_status_pkg.sv
package alarm_status_pkg;
    localparam int NUM_CH    = 2;
    localparam int NUM_SIG   = 5;
    localparam int SYNC_LEN  = 2;
    localparam int BYTE_W    = 8;
    localparam int SEL_W     = 1;

    // signal lanes inside a channel's synchronised vector
    localparam int SIG_LOS   = 0;
    localparam int SIG_AIS   = 1;
    localparam int SIG_BPV   = 2;
    localparam int SIG_OVF   = 3;
    localparam int SIG_AUX   = 4;

    typedef struct packed {
        logic los;
        logic ais;
        logic bpv;
        logic ovf;
        logic aux;
        logic flag;
    } sticky_t;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
    parameter int                WIDTH   = 5,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    logic [WIDTH-1:0] pipe_d [DEPTH];
    logic [WIDTH-1:0] pipe_q [DEPTH];

    always_comb begin
        pipe_d[0] = d_i;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= pipe_d[i];
        end
    end

    assign sync_o = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel
    import alarm_status_pkg::*;
#(
    parameter logic AUX_RST = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SIG-1:0] sync_i,
    input  logic [NUM_SIG-1:0] prev_i,
    input  logic               clr_i,
    output logic [BYTE_W-1:0]  status_o,
    output logic               flag_o
);
    sticky_t st_d, st_q, base;
    logic [NUM_SIG-1:0] rise;
    logic set_los, set_ais, set_bpv, set_ovf, set_aux, ais_fall, set_any;

    always_comb begin
        rise     = sync_i & ~prev_i;
        set_los  = rise[SIG_LOS];
        set_ais  = rise[SIG_AIS];
        set_bpv  = sync_i[SIG_BPV];
        set_ovf  = sync_i[SIG_OVF];
        set_aux  = rise[SIG_AUX];
        ais_fall = ~sync_i[SIG_AIS] & prev_i[SIG_AIS];
        set_any  = set_los | set_ais | set_bpv | set_ovf | set_aux;

        base      = clr_i ? '0 : st_q;
        st_d      = base;
        st_d.los  = base.los  | set_los;
        st_d.ais  = base.ais  | set_ais;
        st_d.bpv  = base.bpv  | set_bpv;
        st_d.ovf  = base.ovf  | set_ovf;
        st_d.aux  = base.aux  | set_aux;
        st_d.flag = base.flag | set_any | ais_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.los  <= 1'b1;
            st_q.aux  <= AUX_RST;
            st_q.flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = {sync_i[SIG_LOS], st_q.los, sync_i[SIG_AIS], st_q.ais,
                       st_q.bpv, st_q.ovf, st_q.aux, st_q.flag};
    assign flag_o   = st_q.flag;

    assert_los_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i[SIG_LOS] && !prev_i[SIG_LOS]) |=> (status_o[6] && flag_o));

    assert_clear_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_any && !ais_fall) |=> (!flag_o && !status_o[6] && !status_o[4]));

    assert_ais_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i[SIG_AIS] && prev_i[SIG_AIS]) |=> flag_o);

    assert_keep_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && sync_i[SIG_BPV]) |=> (status_o[3] && flag_o));
endmodule

// File: rtl/alarm_status_regs.sv
module alarm_status_regs
    import alarm_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] los_i,
    input  logic [NUM_CH-1:0] ais_i,
    input  logic [NUM_CH-1:0] bpv_i,
    input  logic [NUM_CH-1:0] ovf_i,
    input  logic              rst_evt_i,
    input  logic              clk_lost_i,
    input  logic              rd_stb_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0]  aux_vec;
    logic [BYTE_W-1:0]  status [NUM_CH];
    logic [NUM_CH-1:0]  flags;
    logic [BYTE_W-1:0]  rd_data_d, rd_data_q;

    assign aux_vec = {clk_lost_i, rst_evt_i};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [NUM_SIG-1:0] raw, sync, prev;
        logic               clr;

        assign raw = {aux_vec[ch], ovf_i[ch], bpv_i[ch], ais_i[ch], los_i[ch]};
        assign clr = rd_stb_i && (rd_sel_i == SEL_W'(ch));

        alarm_sync #(
            .WIDTH   (NUM_SIG),
            .STAGES  (SYNC_LEN),
            .RST_VAL (NUM_SIG'(1) << SIG_LOS)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (raw),
            .sync_o (sync),
            .prev_o (prev)
        );

        alarm_channel #(
            .AUX_RST (ch == 0)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_i   (sync),
            .prev_i   (prev),
            .clr_i    (clr),
            .status_o (status[ch]),
            .flag_o   (flags[ch])
        );
    end

    always_comb begin
        rd_data_d = rd_data_q;
        if (rd_stb_i) rd_data_d = status[rd_sel_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data_q <= '0;
        else        rd_data_q <= rd_data_d;
    end

    assign rd_data_o = rd_data_q;
    assign irq_o     = |flags;
endmodule

// File: tb/alarm_status_regs_tb.sv
module alarm_status_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] los_i = 2'b11, ais_i = 2'b00, bpv_i = 2'b00, ovf_i = 2'b00;
    logic       rst_evt_i = 1'b0, clk_lost_i = 1'b0;
    logic       rd_stb_i = 1'b0;
    logic [0:0] rd_sel_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_status_regs u_dut (
        .clk(clk), .rst_n(rst_n), .los_i(los_i), .ais_i(ais_i), .bpv_i(bpv_i),
        .ovf_i(ovf_i), .rst_evt_i(rst_evt_i), .clk_lost_i(clk_lost_i),
        .rd_stb_i(rd_stb_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    // behavioural model: lanes 0 los,1 ais,2 bpv,3 ovf,4 bit-1 event; sticky index 5 = flag
    bit   m_in1 [2][5];
    bit   m_live[2][5];
    bit   m_old [2][5];
    bit   m_st  [2][6];
    logic [7:0] m_rd;

    function automatic bit in_bit(int ch, int k);
        case (k)
            0: return los_i[ch];
            1: return ais_i[ch];
            2: return bpv_i[ch];
            3: return ovf_i[ch];
            default: return (ch == 0) ? rst_evt_i : clk_lost_i;
        endcase
    endfunction

    function automatic logic [7:0] m_byte(int ch);
        return {m_live[ch][0], m_st[ch][0], m_live[ch][1], m_st[ch][1],
                m_st[ch][2], m_st[ch][3], m_st[ch][4], m_st[ch][5]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                for (int k = 0; k < 5; k++) begin
                    m_in1[c][k] = (k == 0); m_live[c][k] = (k == 0); m_old[c][k] = (k == 0);
                end
                for (int k = 0; k < 6; k++) m_st[c][k] = 1'b0;
                m_st[c][0] = 1'b1; m_st[c][5] = 1'b1; m_st[c][4] = (c == 0);
            end
            m_rd = 8'h00;
        end else begin
            if (rd_stb_i) m_rd = m_byte(int'(rd_sel_i));
            for (int c = 0; c < 2; c++) begin
                bit ev [5];
                bit fall, any;
                ev[0] = m_live[c][0] && !m_old[c][0];
                ev[1] = m_live[c][1] && !m_old[c][1];
                ev[2] = m_live[c][2];
                ev[3] = m_live[c][3];
                ev[4] = m_live[c][4] && !m_old[c][4];
                fall  = !m_live[c][1] && m_old[c][1];
                any   = ev[0] || ev[1] || ev[2] || ev[3] || ev[4];
                if (rd_stb_i && int'(rd_sel_i) == c)
                    for (int k = 0; k < 6; k++) m_st[c][k] = 1'b0;
                for (int k = 0; k < 5; k++) if (ev[k]) m_st[c][k] = 1'b1;
                if (any || fall) m_st[c][5] = 1'b1;
                for (int k = 0; k < 5; k++) begin
                    m_old[c][k]  = m_live[c][k];
                    m_live[c][k] = m_in1[c][k];
                    m_in1[c][k]  = in_bit(c, k);
                end
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R9 irq_o vs model", {7'd0, irq_o}, {7'd0, m_st[0][5] | m_st[1][5]});
            check("R5 rd_data_o vs model", rd_data_o, m_rd);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input bit sel, input string req, input logic [7:0] exp);
        @(negedge clk);
        rd_stb_i = 1'b1; rd_sel_i = sel;
        @(negedge clk);
        rd_stb_i = 1'b0;
        #1 check(req, rd_data_o, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 check("R3 irq_o in reset", {7'd0, irq_o}, 8'h01);
        rst_n = 1'b1;
        idle(4);
        check("R3 irq_o after reset", {7'd0, irq_o}, 8'h01);
        do_read(0, "R3 R1 channel 0 reset byte", 8'hC3);
        do_read(1, "R3 R2 channel 1 reset byte", 8'hC1);
        do_read(0, "R6 live LOS kept on ch0", 8'h80);
        do_read(1, "R6 live LOS kept on ch1", 8'h80);
        idle(1);
        check("R9 irq low after both cleared", {7'd0, irq_o}, 8'h00);

        los_i = 2'b00; idle(4);
        do_read(0, "R4 live LOS follows input", 8'h00);
        los_i = 2'b01; idle(4);
        check("R9 irq on LOS edge", {7'd0, irq_o}, 8'h01);
        do_read(0, "R4 sticky LOS on rising edge", 8'hC1);
        do_read(0, "R6 second read keeps live LOS", 8'h80);

        ais_i = 2'b10; idle(4);
        do_read(1, "R7 AIS rise sets sticky and flag", 8'h31);
        do_read(1, "R6 live AIS survives read", 8'h20);
        ais_i = 2'b00; idle(4);
        check("R7 irq on AIS fall", {7'd0, irq_o}, 8'h01);
        do_read(1, "R7 AIS fall sets only flag", 8'h01);

        @(negedge clk); bpv_i = 2'b01; @(negedge clk); bpv_i = 2'b00; idle(4);
        do_read(0, "R4 BPV pulse captured", 8'h89);
        @(negedge clk); ovf_i = 2'b10; @(negedge clk); ovf_i = 2'b00; idle(4);
        do_read(1, "R4 overflow pulse captured", 8'h05);

        clk_lost_i = 1'b1; idle(4);
        do_read(1, "R2 clock-lost edge sets bit 1", 8'h03);
        idle(3);
        do_read(1, "R2 held clock-lost does not re-set", 8'h00);
        @(negedge clk); rst_evt_i = 1'b1; @(negedge clk); rst_evt_i = 1'b0; idle(4);
        do_read(0, "R2 reset event sets bit 1 on ch0", 8'h83);

        // R8: LOS rise on ch1 lands in the cycle of a ch1 read
        @(negedge clk); los_i = 2'b11;
        @(negedge clk);
        @(negedge clk); rd_stb_i = 1'b1; rd_sel_i = 1'b1;
        @(negedge clk); rd_stb_i = 1'b0;
        #1 check("R8 read returns pre-event byte", rd_data_o, 8'h80);
        do_read(1, "R8 coincident LOS edge kept", 8'hC1);

        @(negedge clk); bpv_i = 2'b11; @(negedge clk); bpv_i = 2'b00; idle(4);
        do_read(0, "R5 ch0 cleared by its read", 8'h89);
        do_read(1, "R5 ch1 untouched by ch0 read", 8'h89);
        do_read(0, "R5 ch0 stays cleared", 8'h80);

        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) los_i[$urandom_range(0, 1)] ^= 1'b1;
            if ($urandom_range(0, 15) == 0) ais_i[$urandom_range(0, 1)] ^= 1'b1;
            bpv_i = ($urandom_range(0, 19) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            ovf_i = ($urandom_range(0, 19) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            rst_evt_i = ($urandom_range(0, 29) == 0);
            if ($urandom_range(0, 25) == 0) clk_lost_i = ~clk_lost_i;
            rd_stb_i = ($urandom_range(0, 3) == 0);
            rd_sel_i = 1'($urandom_range(0, 1));
        end
        @(negedge clk); rd_stb_i = 1'b0;
        idle(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule